// File: doc/BRIEF.md
# Zero-Suppressed ADC Readout Formatter

This block runs the digitization and sparse readout of one 64-channel front-end module after an accept. It steps four parallel ADC conversion paths through their sixteen channels. For each step it issues one conversion request and waits for the returned set of four 8-bit samples. Each sample is compared with a programmable threshold, and only channels whose value lies above it are placed on a byte-wide link with a valid strobe.

Each surviving channel is sent as an address byte followed by a value byte. An event ends with a single marker byte. The next conversion starts as soon as the previous results have been handed to the output side. This lets conversion and transmission overlap. Accepts that arrive during a readout do not start a new one; they only increment a saturating counter.

Top module: `zs_readout_fmt`

## Requirements
- R1: After reset, `link_valid` and `conv_start` are low and `drop_cnt` is zero.
- R2: An accept while idle starts a scan. The scan issues exactly 16 single-cycle `conv_start` pulses, with `conv_step` taking the values 0, 1, ..., 15 in order. A new pulse is issued only after the result of the previous one has arrived on `adc_valid`.
- R3: A channel is a hit only when its sample is strictly greater than `thresh`. A sample equal to or below `thresh` produces no output bytes.
- R4: Each hit appears as two bytes on consecutive `link_valid` cycles. The first is the address `{mod_id[1:0], chan[5:0]}`, where chan = path*16 + step and path p is taken from `adc_data[8p+7:8p]`. The second is the sample value.
- R5: Hits are sent in step order. Within one step, lower paths (lower channel numbers) are sent first.
- R6: After the last hit of step 15, exactly one byte 8'hFF is sent with `link_valid`, and the block returns to idle.
- R7: An accept while a readout is in progress neither starts nor disturbs a readout. It increments `drop_cnt` by one, and the counter saturates at 255.
- R8: `link_valid` stays low while no readout is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| accept | input | 1 | Readout request pulse |
| thresh | input | 8 | Suppression threshold |
| mod_id | input | 2 | Module index placed in the address byte |
| adc_valid | input | 1 | Conversion result available |
| adc_data | input | 32 | Four 8-bit samples, path p in bits 8p+7:8p |
| conv_start | output | 1 | Conversion request pulse |
| conv_step | output | 4 | Channel index within each path for the request |
| link_data | output | 8 | Output byte |
| link_valid | output | 1 | Output byte valid |
| drop_cnt | output | 8 | Count of accepts ignored while busy |

## Verification
The formatter is exercised with several sample patterns:
- All samples equal to the threshold, which must yield only the end marker and so separates strict from non-strict comparison.
- All samples one above the threshold, which fills every step with four hits and stresses the case where output drains slower than conversion.
- Sparse random hits over random thresholds and module indices, which check address packing and channel ordering against an independent model.
- Data bytes of 8'hFF, which show that the end marker is found by position and not by value.

Accepts are also pulsed during a readout. This confirms that the byte stream is unchanged and that the drop counter moves by the right amount.

// File: rtl/zs_pkg.sv
package zs_pkg;
    parameter int unsigned NUM_PATHS   = 4;
    parameter int unsigned CH_PER_PATH = 16;
    parameter int unsigned BYTE_W      = 8;

    localparam int unsigned STEP_W = $clog2(CH_PER_PATH);
    localparam int unsigned PATH_W = $clog2(NUM_PATHS);
    localparam int unsigned CHAN_W = STEP_W + PATH_W;
    localparam int unsigned MOD_W  = BYTE_W - CHAN_W;
    localparam logic [BYTE_W-1:0] END_MARK = '1;

    typedef logic [BYTE_W-1:0] sample_t;
    typedef logic [STEP_W-1:0] step_t;
    typedef logic [PATH_W-1:0] path_t;
    typedef logic [NUM_PATHS-1:0] mask_t;

    typedef struct packed {
        sample_t [NUM_PATHS-1:0] val;
        logic                    last;
        step_t                   step;
    } batch_t;

    typedef enum logic {PH_ADDR, PH_DATA} phase_e;

    // Lowest set bit index of a hit mask (0 if empty).
    function automatic path_t lowest_hit(mask_t m);
        path_t idx = '0;
        for (int i = NUM_PATHS - 1; i >= 0; i--) begin
            if (m[i]) idx = path_t'(i);
        end
        return idx;
    endfunction

    function automatic sample_t pack_addr(logic [MOD_W-1:0] mod, path_t p, step_t s);
        return {mod, p, s};
    endfunction
endpackage

// File: rtl/zs_hit_filter.sv
module zs_hit_filter
    import zs_pkg::*;
(
    input  batch_t  batch,
    input  sample_t thresh,
    output mask_t   hits
);
    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_cmp
        assign hits[p] = batch.val[p] > thresh;
    end
endmodule

// File: rtl/zs_scan_ctrl.sv
module zs_scan_ctrl
    import zs_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic                        adc_valid,
    input  logic [NUM_PATHS*BYTE_W-1:0] adc_data,
    input  logic                        em_ready,
    output logic                        em_load,
    output batch_t                      batch,
    output logic                        conv_start,
    output step_t                       conv_step
);
    localparam step_t LAST_STEP = step_t'(CH_PER_PATH - 1);

    logic                    waiting_q;
    logic                    pend_q;
    logic                    pend_last_q;
    sample_t [NUM_PATHS-1:0] pend_val_q;

    assign em_load = pend_q && em_ready;

    always_comb begin
        batch.val  = pend_val_q;
        batch.last = pend_last_q;
        batch.step = conv_step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_start  <= 1'b0;
            conv_step   <= '0;
            waiting_q   <= 1'b0;
            pend_q      <= 1'b0;
            pend_last_q <= 1'b0;
            pend_val_q  <= '0;
        end else begin
            conv_start <= 1'b0;
            if (start) begin
                conv_start <= 1'b1;
                conv_step  <= '0;
                waiting_q  <= 1'b1;
            end
            if (waiting_q && adc_valid) begin
                waiting_q   <= 1'b0;
                pend_q      <= 1'b1;
                pend_last_q <= (conv_step == LAST_STEP);
                for (int p = 0; p < NUM_PATHS; p++) begin
                    pend_val_q[p] <= adc_data[p*BYTE_W +: BYTE_W];
                end
            end
            if (em_load) begin
                pend_q <= 1'b0;
                if (!pend_last_q) begin
                    conv_start <= 1'b1;
                    conv_step  <= conv_step + 1'b1;
                    waiting_q  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/zs_link_emitter.sv
module zs_link_emitter
    import zs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  batch_t           batch,
    input  mask_t            hits,
    input  logic [MOD_W-1:0] mod_id,
    output logic             ready,
    output sample_t          link_data,
    output logic             link_valid,
    output logic             done
);
    sample_t [NUM_PATHS-1:0] val_q;
    mask_t                   mask_q;
    logic                    last_q;
    step_t                   step_q;
    phase_e                  phase_q;
    path_t                   sel;

    assign sel   = lowest_hit(mask_q);
    assign ready = (mask_q == '0) && !last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q      <= '0;
            mask_q     <= '0;
            last_q     <= 1'b0;
            step_q     <= '0;
            phase_q    <= PH_ADDR;
            link_data  <= '0;
            link_valid <= 1'b0;
            done       <= 1'b0;
        end else begin
            link_valid <= 1'b0;
            done       <= 1'b0;
            if (load) begin
                val_q   <= batch.val;
                mask_q  <= hits;
                last_q  <= batch.last;
                step_q  <= batch.step;
                phase_q <= PH_ADDR;
            end else if (mask_q != '0) begin
                link_valid <= 1'b1;
                if (phase_q == PH_ADDR) begin
                    link_data <= pack_addr(mod_id, sel, step_q);
                    phase_q   <= PH_DATA;
                end else begin
                    link_data   <= val_q[sel];
                    mask_q[sel] <= 1'b0;
                    phase_q     <= PH_ADDR;
                end
            end else if (last_q) begin
                link_valid <= 1'b1;
                link_data  <= END_MARK;
                last_q     <= 1'b0;
                done       <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/zs_readout_fmt.sv
module zs_readout_fmt
    import zs_pkg::*;
#(
    parameter int unsigned DROP_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        accept,
    input  logic [BYTE_W-1:0]           thresh,
    input  logic [MOD_W-1:0]            mod_id,
    input  logic                        adc_valid,
    input  logic [NUM_PATHS*BYTE_W-1:0] adc_data,
    output logic                        conv_start,
    output logic [STEP_W-1:0]           conv_step,
    output logic [BYTE_W-1:0]           link_data,
    output logic                        link_valid,
    output logic [DROP_W-1:0]           drop_cnt
);
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    logic   busy_q;
    logic   start;
    logic   em_ready;
    logic   em_load;
    logic   em_done;
    batch_t batch;
    mask_t  hits;

    assign start = accept && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            drop_cnt <= '0;
        end else begin
            if (start)        busy_q <= 1'b1;
            else if (em_done) busy_q <= 1'b0;
            if (accept && busy_q && drop_cnt != DROP_MAX) drop_cnt <= drop_cnt + 1'b1;
        end
    end

    zs_scan_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .adc_valid  (adc_valid),
        .adc_data   (adc_data),
        .em_ready   (em_ready),
        .em_load    (em_load),
        .batch      (batch),
        .conv_start (conv_start),
        .conv_step  (conv_step)
    );

    zs_hit_filter u_filt (
        .batch  (batch),
        .thresh (thresh),
        .hits   (hits)
    );

    zs_link_emitter u_emit (
        .clk        (clk),
        .rst        (rst),
        .load       (em_load),
        .batch      (batch),
        .hits       (hits),
        .mod_id     (mod_id),
        .ready      (em_ready),
        .link_data  (link_data),
        .link_valid (link_valid),
        .done       (em_done)
    );
endmodule

// File: rtl/zs_checker.sv
module zs_checker (
    input logic       clk,
    input logic       rst,
    input logic       accept,
    input logic       busy,
    input logic       conv_start,
    input logic       link_valid,
    input logic [7:0] link_data,
    input logic [7:0] drop_cnt
);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !link_valid);

    assert_conv_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    assert_conv_in_scan_R2: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> busy);

    assert_end_mark_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(link_valid) && $past(link_data) == 8'hFF));

    assert_drop_count_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && busy && drop_cnt != 8'hFF) |=> drop_cnt == $past(drop_cnt) + 8'd1);

    assert_drop_sat_R7: assert property (@(posedge clk) disable iff (rst)
        (drop_cnt == 8'hFF) |=> drop_cnt == 8'hFF);
endmodule

bind zs_readout_fmt zs_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .busy       (busy_q),
    .conv_start (conv_start),
    .link_valid (link_valid),
    .link_data  (link_data),
    .drop_cnt   (drop_cnt)
);

// File: tb/tb_zs_readout_fmt.sv
module tb_zs_readout_fmt;
    localparam int ADC_LAT = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        accept = 1'b0;
    logic [7:0]  thresh = '0;
    logic [1:0]  mod_id = '0;
    logic        adc_valid = 1'b0;
    logic [31:0] adc_data = '0;
    logic        conv_start;
    logic [3:0]  conv_step;
    logic [7:0]  link_data;
    logic        link_valid;
    logic [7:0]  drop_cnt;

    int tests = 0;
    int fails = 0;

    logic [7:0] smp [4][16];
    logic [7:0] got [0:511];
    logic [7:0] expb [0:255];
    int n_got = 0;
    int n_exp = 0;
    int conv_cnt = 0;
    int step_err = 0;
    int drop_exp = 0;

    zs_readout_fmt dut (
        .clk(clk), .rst(rst), .accept(accept), .thresh(thresh), .mod_id(mod_id),
        .adc_valid(adc_valid), .adc_data(adc_data), .conv_start(conv_start),
        .conv_step(conv_step), .link_data(link_data), .link_valid(link_valid),
        .drop_cnt(drop_cnt)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // ADC model: answers each request after a fixed latency.
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start && !rst) begin
                automatic logic [3:0] s = conv_step;
                if (int'(s) != conv_cnt) step_err++;
                conv_cnt++;
                repeat (ADC_LAT) @(negedge clk);
                for (int p = 0; p < 4; p++) adc_data[p*8 +: 8] = smp[p][s];
                adc_valid = 1'b1;
                @(negedge clk);
                adc_valid = 1'b0;
            end
        end
    end

    // Byte collector.
    initial begin
        forever begin
            @(negedge clk);
            if (link_valid && n_got < 512) begin
                got[n_got] = link_data;
                n_got++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic build_expected();
        n_exp = 0;
        for (int s = 0; s < 16; s++) begin
            for (int p = 0; p < 4; p++) begin
                if (smp[p][s] > thresh) begin
                    expb[n_exp]     = {mod_id, p[1:0], s[3:0]};
                    expb[n_exp + 1] = smp[p][s];
                    n_exp += 2;
                end
            end
        end
        expb[n_exp] = 8'hFF;
        n_exp++;
    endtask

    task automatic run_event(input int extra_acc);
        int cyc;
        int bad;
        build_expected();
        n_got = 0;
        conv_cnt = 0;
        step_err = 0;
        @(negedge clk);
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
        for (int k = 0; k < extra_acc; k++) begin
            repeat (7) @(negedge clk);
            accept = 1'b1;
            drop_exp++;
            @(negedge clk);
            accept = 1'b0;
        end
        cyc = 0;
        while (n_got < n_exp && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        repeat (20) @(negedge clk);
        check(n_got == n_exp, "R6 byte count", n_got, n_exp);
        bad = -1;
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            if (bad < 0 && got[i] != expb[i]) bad = i;
        end
        if (bad >= 0) check(1'b0, "R3 R4 R5 stream byte", int'(got[bad]), int'(expb[bad]));
        else check(1'b1, "R3 R4 R5 stream", 0, 0);
        check(n_got > 0 && got[n_got-1] == 8'hFF, "R6 end marker", n_got > 0 ? int'(got[n_got-1]) : -1, 255);
        check(conv_cnt == 16 && step_err == 0, "R2 conversions", conv_cnt, 16);
        check(int'(drop_cnt) == drop_exp, "R7 drop count", int'(drop_cnt), drop_exp);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        for (int p = 0; p < 4; p++) for (int s = 0; s < 16; s++) smp[p][s] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!link_valid && !conv_start && drop_cnt == 0, "R1 reset state",
              {link_valid, conv_start, drop_cnt}, 0);

        // R8: idle, nothing leaves the link.
        n_got = 0;
        repeat (50) @(negedge clk);
        check(n_got == 0, "R8 idle quiet", n_got, 0);

        // R3: samples equal to threshold are suppressed.
        thresh = 8'd40; mod_id = 2'd1;
        for (int p = 0; p < 4; p++) for (int s = 0; s < 16; s++) smp[p][s] = 8'd40;
        run_event(0);

        // R3/R5: one above threshold, all channels hit, stalls emitter.
        for (int p = 0; p < 4; p++) for (int s = 0; s < 16; s++) smp[p][s] = 8'd41;
        mod_id = 2'd3;
        run_event(0);

        // Data bytes equal to 8'hFF; accepts during busy (R7).
        thresh = 8'd200; mod_id = 2'd2;
        for (int p = 0; p < 4; p++) for (int s = 0; s < 16; s++)
            smp[p][s] = ((p + s) % 3 == 0) ? 8'hFF : 8'd10;
        run_event(3);

        // Random events.
        for (int e = 0; e < 16; e++) begin
            thresh = 8'($urandom_range(0, 250));
            mod_id = 2'($urandom_range(0, 3));
            for (int p = 0; p < 4; p++) for (int s = 0; s < 16; s++) begin
                if ($urandom_range(0, 3) == 0) smp[p][s] = 8'($urandom_range(0, 255));
                else smp[p][s] = 8'($urandom_range(0, int'(thresh)));
            end
            run_event(int'($urandom_range(0, 2)));
        end

        // R8 after events: still quiet.
        n_got = 0;
        repeat (40) @(negedge clk);
        check(n_got == 0, "R8 idle after events", n_got, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule